// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block remaps outbound request addresses through a small set of programmable regions. Software never addresses a region's registers directly. It first writes a viewport register, which picks a direction and a region index. It then reads and writes that region's control, base, limit and target words through one shared register window. Writes made while the inbound direction is selected land in a separate inbound bank. That bank can be read back but does not take part in translation.

Each request is compared against every enabled outbound region in the same cycle. A region claims the request when the address lies between its base and its limit, both ends included. The response then carries the target plus the offset from the base, the region's transaction type and the index of the winning region. When no region claims the request, the address passes through unchanged and a miss flag is raised. For configuration types, the target word encodes the bus, device and function of the request.

The request and response sides form one valid/ready stream with no storage between them. `rsp_valid` follows `req_valid` and `req_ready` follows `rsp_ready` in the same cycle. A stalled response therefore stalls the request. While the response is stalled, the response fields follow the request address held at the input and the current region registers. The register port is a plain single-cycle write port with a combinational read path.

Top module: `ob_xlate_unit`

## Requirements
- R1: After reset, every region in both banks is disabled and holds zero, the viewport reads 0, and every request misses.
- R2: The viewport register at offset 0x900 keeps bit 31 as direction (1 inbound, 0 outbound) and bit 0 as region index. It reads back with all other bits zero.
- R3: Offsets 0x904 (type in bits 4:0), 0x908 (bit 31 enable, bit 30 base-match mode), 0x90C (base low), 0x910 (base high), 0x914 (limit low), 0x918 (target low) and 0x91C (target high) read and write the region chosen by the viewport. Other regions keep their values.
- R4: A request hits an enabled outbound region when {base high, base low} <= address <= {base high, limit low}. Both ends are inclusive.
- R5: On a hit, the response address equals {target high, target low} + (address - base).
- R6: On a hit, the response type equals the region's type code (memory 0, I/O 2, type-0 config 4, type-1 config 5). A target low word holding bus in bits 31:24, device in 23:19 and function in 18:16 appears unchanged at those bit positions for an offset below 64 KiB.
- R7: When several regions hit, the lowest index wins and is reported on `rsp_region`.
- R8: When no region hits, `rsp_miss` is 1, the response address equals the request address and the type is 0.
- R9: Writes with the inbound direction selected change only the inbound bank. They read back with inbound selected and leave outbound readback and translation unchanged.
- R10: `rsp_valid` equals `req_valid` and `req_ready` equals `rsp_ready` in the same cycle.
- R11: A disabled region never hits, and the base-match mode bit has no effect on translation.
- R12: Reads from unmapped offsets return 0, and writes to them change no register and no translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 12 | Register byte offset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Downstream ready |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_type | output | 5 | Transaction type of the hitting region, 0 on miss |
| rsp_miss | output | 1 | No region hit |
| rsp_region | output | 1 | Index of the hitting region |

## Verification
The bench uses the default build: two regions and 64-bit addresses. At that size it can read back every window offset of both regions in both banks, and compute every response with plain arithmetic. Addresses are swept two steps on each side of each base and each limit, so both inclusive edges and their first outside neighbours are covered. Overlapping, disabled and base-match-mode regions are then compared against the same arithmetic model. The single region-index bit allows every combination of viewport direction and index to be reached.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;
  localparam int WORD_W  = 32;
  localparam int TYPE_W  = 5;
  localparam int OFF_W   = 12;
  localparam int DIR_BIT = 31;
  localparam int EN_BIT  = 31;
  localparam int BAR_BIT = 30;

  localparam logic [OFF_W-1:0] OFF_VIEW  = 12'h900;
  localparam logic [OFF_W-1:0] OFF_CTL1  = 12'h904;
  localparam logic [OFF_W-1:0] OFF_CTL2  = 12'h908;
  localparam logic [OFF_W-1:0] OFF_LBASE = 12'h90C;
  localparam logic [OFF_W-1:0] OFF_UBASE = 12'h910;
  localparam logic [OFF_W-1:0] OFF_LIMIT = 12'h914;
  localparam logic [OFF_W-1:0] OFF_LTGT  = 12'h918;
  localparam logic [OFF_W-1:0] OFF_UTGT  = 12'h91C;

  localparam logic [TYPE_W-1:0] KIND_MEM  = 5'd0;
  localparam logic [TYPE_W-1:0] KIND_IO   = 5'd2;
  localparam logic [TYPE_W-1:0] KIND_CFG0 = 5'd4;
  localparam logic [TYPE_W-1:0] KIND_CFG1 = 5'd5;

  typedef enum logic [2:0] {
    WIN_CTL1, WIN_CTL2, WIN_LBASE, WIN_UBASE,
    WIN_LIMIT, WIN_LTGT, WIN_UTGT, WIN_NONE
  } win_e;

  typedef struct packed {
    logic [TYPE_W-1:0] kind;
    logic              en;
    logic              bar;
    logic [WORD_W-1:0] lbase;
    logic [WORD_W-1:0] ubase;
    logic [WORD_W-1:0] limit;
    logic [WORD_W-1:0] ltgt;
    logic [WORD_W-1:0] utgt;
  } region_t;

  function automatic win_e win_decode(input logic [OFF_W-1:0] off);
    case (off)
      OFF_CTL1:  return WIN_CTL1;
      OFF_CTL2:  return WIN_CTL2;
      OFF_LBASE: return WIN_LBASE;
      OFF_UBASE: return WIN_UBASE;
      OFF_LIMIT: return WIN_LIMIT;
      OFF_LTGT:  return WIN_LTGT;
      OFF_UTGT:  return WIN_UTGT;
      default:   return WIN_NONE;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] win_read(input region_t r, input win_e s);
    logic [WORD_W-1:0] w;
    w = '0;
    case (s)
      WIN_CTL1:  w[TYPE_W-1:0] = r.kind;
      WIN_CTL2:  begin w[EN_BIT] = r.en; w[BAR_BIT] = r.bar; end
      WIN_LBASE: w = r.lbase;
      WIN_UBASE: w = r.ubase;
      WIN_LIMIT: w = r.limit;
      WIN_LTGT:  w = r.ltgt;
      WIN_UTGT:  w = r.utgt;
      default:   w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/ob_xlate_bank.sv
module ob_xlate_bank
  import ob_xlate_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int IDX_W       = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  win_e                          wr_sel,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [WORD_W-1:0]             wr_data,
  output region_t [NUM_REGIONS-1:0]     regs
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    region_t r_q;
    logic    hit_w;
    assign hit_w = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        r_q <= '0;
      end else if (hit_w) begin
        case (wr_sel)
          WIN_CTL1:  r_q.kind  <= wr_data[TYPE_W-1:0];
          WIN_CTL2:  begin
            r_q.en  <= wr_data[EN_BIT];
            r_q.bar <= wr_data[BAR_BIT];
          end
          WIN_LBASE: r_q.lbase <= wr_data;
          WIN_UBASE: r_q.ubase <= wr_data;
          WIN_LIMIT: r_q.limit <= wr_data;
          WIN_LTGT:  r_q.ltgt  <= wr_data;
          WIN_UTGT:  r_q.utgt  <= wr_data;
          default:   r_q       <= r_q;
        endcase
      end
    end
    assign regs[g] = r_q;
  end
endmodule

// File: rtl/ob_xlate_match.sv
module ob_xlate_match
  import ob_xlate_pkg::*;
#(
  parameter int AW = 2 * WORD_W
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] top,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] xaddr
);
  logic above_base, below_top;
  assign above_base = (addr >= base);
  assign below_top  = (addr <= top);
  assign hit        = en && above_base && below_top;
  assign xaddr      = target + (addr - base);
endmodule

// File: rtl/ob_xlate_pick.sv
module ob_xlate_pick
  import ob_xlate_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int IDX_W       = 1,
  parameter int AW          = 2 * WORD_W
) (
  input  logic [NUM_REGIONS-1:0]             hit_vec,
  input  logic [NUM_REGIONS-1:0][AW-1:0]     xaddr_vec,
  input  logic [NUM_REGIONS-1:0][TYPE_W-1:0] kind_vec,
  input  logic [AW-1:0]                      pass_addr,
  output logic                               miss,
  output logic [IDX_W-1:0]                   region,
  output logic [AW-1:0]                      out_addr,
  output logic [TYPE_W-1:0]                  out_kind
);
  always_comb begin
    miss     = 1'b1;
    region   = '0;
    out_addr = pass_addr;
    out_kind = KIND_MEM;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        miss     = 1'b0;
        region   = IDX_W'(i);
        out_addr = xaddr_vec[i];
        out_kind = kind_vec[i];
      end
    end
  end
endmodule

// File: rtl/ob_xlate_unit.sv
module ob_xlate_unit
  import ob_xlate_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int AW    = 2 * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OFF_W-1:0]   cfg_addr,
  input  logic               cfg_we,
  input  logic [WORD_W-1:0]  cfg_wdata,
  output logic [WORD_W-1:0]  cfg_rdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [AW-1:0]      rsp_addr,
  output logic [TYPE_W-1:0]  rsp_type,
  output logic               rsp_miss,
  output logic [IDX_W-1:0]   rsp_region
);
  localparam logic [IDX_W:0] NREG = (IDX_W + 1)'(NUM_REGIONS);

  logic             vp_dir;
  logic [IDX_W-1:0] vp_idx;
  logic             idx_ok;
  win_e             wsel;
  logic             ob_we, ib_we;

  region_t [NUM_REGIONS-1:0]             ob_regs, ib_regs;
  logic    [NUM_REGIONS-1:0]             hit_vec, ob_en;
  logic    [NUM_REGIONS-1:0][AW-1:0]     xaddr_vec;
  logic    [NUM_REGIONS-1:0][TYPE_W-1:0] kind_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      vp_dir <= 1'b0;
      vp_idx <= '0;
    end else if (cfg_we && cfg_addr == OFF_VIEW) begin
      vp_dir <= cfg_wdata[DIR_BIT];
      vp_idx <= cfg_wdata[IDX_W-1:0];
    end
  end

  assign idx_ok = ({1'b0, vp_idx} < NREG);
  assign wsel   = win_decode(cfg_addr);
  assign ob_we  = cfg_we && !vp_dir && idx_ok && (wsel != WIN_NONE);
  assign ib_we  = cfg_we &&  vp_dir && idx_ok && (wsel != WIN_NONE);

  ob_xlate_bank #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_ob_bank (
    .clk(clk), .rst(rst), .wr_en(ob_we), .wr_sel(wsel),
    .wr_idx(vp_idx), .wr_data(cfg_wdata), .regs(ob_regs)
  );

  ob_xlate_bank #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_ib_bank (
    .clk(clk), .rst(rst), .wr_en(ib_we), .wr_sel(wsel),
    .wr_idx(vp_idx), .wr_data(cfg_wdata), .regs(ib_regs)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == OFF_VIEW) begin
      cfg_rdata[DIR_BIT]     = vp_dir;
      cfg_rdata[IDX_W-1:0]   = vp_idx;
    end else if (idx_ok && wsel != WIN_NONE) begin
      cfg_rdata = win_read(vp_dir ? ib_regs[vp_idx] : ob_regs[vp_idx], wsel);
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    assign ob_en[g]    = ob_regs[g].en;
    assign kind_vec[g] = ob_regs[g].kind;
    ob_xlate_match #(.AW(AW)) u_match (
      .en    (ob_regs[g].en),
      .base  ({ob_regs[g].ubase, ob_regs[g].lbase}),
      .top   ({ob_regs[g].ubase, ob_regs[g].limit}),
      .target({ob_regs[g].utgt,  ob_regs[g].ltgt}),
      .addr  (req_addr),
      .hit   (hit_vec[g]),
      .xaddr (xaddr_vec[g])
    );
  end

  ob_xlate_pick #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W), .AW(AW)) u_pick (
    .hit_vec(hit_vec), .xaddr_vec(xaddr_vec), .kind_vec(kind_vec),
    .pass_addr(req_addr), .miss(rsp_miss), .region(rsp_region),
    .out_addr(rsp_addr), .out_kind(rsp_type)
  );

  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;
endmodule

// File: rtl/ob_xlate_unit_chk.sv
module ob_xlate_unit_chk
  import ob_xlate_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int IDX_W       = 1,
  parameter int AW          = 64
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_we,
  input logic                   vp_dir,
  input logic                   req_valid,
  input logic [AW-1:0]          req_addr,
  input logic                   rsp_valid,
  input logic [AW-1:0]          rsp_addr,
  input logic [TYPE_W-1:0]      rsp_type,
  input logic                   rsp_miss,
  input logic [IDX_W-1:0]       rsp_region,
  input logic [NUM_REGIONS-1:0] hit_vec,
  input logic [NUM_REGIONS-1:0] ob_en
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ob_en == '0));

  p_region_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_miss) |-> hit_vec[rsp_region]);

  p_low_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit_vec[0]) |-> (!rsp_miss && rsp_region == '0));

  p_miss_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_miss) |-> (rsp_addr == req_addr && rsp_type == '0));

  p_inbound_apart_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && vp_dir) |=> $stable(ob_en));

  p_enabled_only_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_miss) |-> ob_en[rsp_region]);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(ob_en));
endmodule

bind ob_xlate_unit ob_xlate_unit_chk #(
  .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .vp_dir(vp_dir),
  .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_addr(rsp_addr), .rsp_type(rsp_type), .rsp_miss(rsp_miss),
  .rsp_region(rsp_region), .hit_vec(hit_vec), .ob_en(ob_en)
);

// File: tb/ob_xlate_unit_tb.sv
`timescale 1ns/1ps
module ob_xlate_unit_tb;
  import ob_xlate_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cfg_addr = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic [4:0]  rsp_type;
  logic        rsp_miss;
  logic [0:0]  rsp_region;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] m_base [2];
  logic [31:0] m_lim  [2];
  logic [63:0] m_tgt  [2];
  logic [4:0]  m_ty   [2];
  bit          m_en   [2];

  always #2 clk = ~clk;

  ob_xlate_unit u_dut (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_type(rsp_type),
    .rsp_miss(rsp_miss), .rsp_region(rsp_region)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = off; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] off, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = off;
    #1;
    chk(cfg_rdata == exp, tag, {32'b0, cfg_rdata}, {32'b0, exp});
  endtask

  task automatic view(input bit dir, input int idx);
    wr(OFF_VIEW, {dir, 30'b0, idx[0]});
  endtask

  task automatic prog(input bit dir, input int idx, input logic [4:0] ty, input bit en,
                      input bit bar, input logic [63:0] base, input logic [31:0] lim,
                      input logic [63:0] tgt);
    view(dir, idx);
    wr(OFF_CTL1, {27'b0, ty});
    wr(OFF_CTL2, {en, bar, 30'b0});
    wr(OFF_LBASE, base[31:0]);
    wr(OFF_UBASE, base[63:32]);
    wr(OFF_LIMIT, lim);
    wr(OFF_LTGT, tgt[31:0]);
    wr(OFF_UTGT, tgt[63:32]);
    if (!dir) begin
      m_base[idx] = base; m_lim[idx] = lim; m_tgt[idx] = tgt;
      m_ty[idx] = ty; m_en[idx] = en;
    end
  endtask

  task automatic readback(input logic [4:0] ty, input bit en, input bit bar,
                          input logic [63:0] base, input logic [31:0] lim,
                          input logic [63:0] tgt, input string tag);
    rd_chk(OFF_CTL1, {27'b0, ty}, tag);
    rd_chk(OFF_CTL2, {en, bar, 30'b0}, tag);
    rd_chk(OFF_LBASE, base[31:0], tag);
    rd_chk(OFF_UBASE, base[63:32], tag);
    rd_chk(OFF_LIMIT, lim, tag);
    rd_chk(OFF_LTGT, tgt[31:0], tag);
    rd_chk(OFF_UTGT, tgt[63:32], tag);
  endtask

  task automatic req_chk(input logic [63:0] a, input string tag);
    logic        e_miss;
    logic        e_reg;
    logic [63:0] e_addr;
    logic [4:0]  e_ty;
    @(negedge clk);
    req_addr = a; req_valid = 1'b1; rsp_ready = 1'b1;
    #1;
    e_miss = 1'b1; e_reg = 1'b0; e_addr = a; e_ty = 5'd0;
    for (int r = 1; r >= 0; r--) begin
      if (m_en[r] && a >= m_base[r] && a <= {m_base[r][63:32], m_lim[r]}) begin
        e_miss = 1'b0; e_reg = r[0];
        e_addr = m_tgt[r] + (a - m_base[r]);
        e_ty = m_ty[r];
      end
    end
    chk(rsp_miss == e_miss, {tag, " miss"}, {63'b0, rsp_miss}, {63'b0, e_miss});
    chk(rsp_addr == e_addr, {tag, " addr"}, rsp_addr, e_addr);
    chk(rsp_type == e_ty, {tag, " type"}, {59'b0, rsp_type}, {59'b0, e_ty});
    if (!e_miss)
      chk(rsp_region == e_reg, {tag, " region"}, {63'b0, rsp_region}, {63'b0, e_reg});
  endtask

  task automatic sweep(input int r, input string tag);
    logic [63:0] top;
    top = {m_base[r][63:32], m_lim[r]};
    for (int d = -2; d <= 2; d++) begin
      req_chk(m_base[r] + 64'(d), tag);
      req_chk(top + 64'(d), tag);
    end
    req_chk(m_base[r] + ((top - m_base[r]) >> 1), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 2; r++) begin
      m_base[r] = '0; m_lim[r] = '0; m_tgt[r] = '0; m_ty[r] = '0; m_en[r] = 1'b0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state of viewport, both outbound regions and the inbound bank
    rd_chk(OFF_VIEW, 32'h0, "R1 viewport");
    readback(5'd0, 1'b0, 1'b0, 64'h0, 32'h0, 64'h0, "R1 region0");
    view(1'b0, 1); readback(5'd0, 1'b0, 1'b0, 64'h0, 32'h0, 64'h0, "R1 region1");
    view(1'b1, 0); readback(5'd0, 1'b0, 1'b0, 64'h0, 32'h0, 64'h0, "R1 inbound0");
    req_chk(64'h0, "R1 miss");
    req_chk(64'h1234_5678_9ABC_DEF0, "R1 miss");

    // R2: viewport field masking
    wr(OFF_VIEW, 32'h8000_0001); rd_chk(OFF_VIEW, 32'h8000_0001, "R2 readback");
    wr(OFF_VIEW, 32'hFFFF_FFFE); rd_chk(OFF_VIEW, 32'h8000_0000, "R2 mask");
    wr(OFF_VIEW, 32'h7FFF_FFFF); rd_chk(OFF_VIEW, 32'h0000_0001, "R2 mask");

    // R11: programmed but disabled regions never hit
    prog(1'b0, 0, KIND_MEM, 1'b0, 1'b0, 64'h1_1000_0000, 32'h1000_FFFF, 64'h4000_0000);
    sweep(0, "R11 disabled");

    // R3: program both regions, read back through the window
    prog(1'b0, 0, KIND_MEM, 1'b1, 1'b0, 64'h1_1000_0000, 32'h1000_FFFF, 64'h4000_0000);
    prog(1'b0, 1, KIND_CFG0, 1'b1, 1'b0, 64'h2000_0000, 32'h2000_0FFF, 64'h0000_0000_032A_0000);
    view(1'b0, 0);
    readback(KIND_MEM, 1'b1, 1'b0, 64'h1_1000_0000, 32'h1000_FFFF, 64'h4000_0000, "R3 region0");
    view(1'b0, 1);
    readback(KIND_CFG0, 1'b1, 1'b0, 64'h2000_0000, 32'h2000_0FFF, 64'h032A_0000, "R3 region1");

    // R4 R5 R6: boundary sweeps of both regions
    sweep(0, "R4 R5 region0");
    sweep(1, "R4 R6 region1");
    req_chk(64'h2000_0010, "R6 cfg");
    chk(rsp_addr[31:24] == 8'd3, "R6 bus", {56'b0, rsp_addr[31:24]}, 64'd3);
    chk(rsp_addr[23:19] == 5'd5, "R6 device", {59'b0, rsp_addr[23:19]}, 64'd5);
    chk(rsp_addr[18:16] == 3'd2, "R6 function", {61'b0, rsp_addr[18:16]}, 64'd2);

    // R6: every type code on region 1
    begin
      logic [4:0] kinds [4];
      kinds[0] = KIND_MEM; kinds[1] = KIND_IO; kinds[2] = KIND_CFG0; kinds[3] = KIND_CFG1;
      for (int k = 0; k < 4; k++) begin
        view(1'b0, 1); wr(OFF_CTL1, {27'b0, kinds[k]}); m_ty[1] = kinds[k];
        req_chk(64'h2000_0800, "R6 type sweep");
      end
    end

    // R7: overlapping regions, low index wins
    prog(1'b0, 1, KIND_IO, 1'b1, 1'b0, 64'h1_1000_8000, 32'h1001_FFFF, 64'h9000_0000);
    sweep(1, "R7 overlap");
    req_chk(64'h1_1000_9000, "R7 both hit");

    // R11: base-match mode bit has no effect; disabling region 0 exposes region 1
    view(1'b0, 0); wr(OFF_CTL2, 32'hC000_0000);
    req_chk(64'h1_1000_9000, "R11 bar bit");
    wr(OFF_CTL2, 32'h4000_0000); m_en[0] = 1'b0;
    req_chk(64'h1_1000_9000, "R11 disabled region0");
    req_chk(64'h1_1000_0000, "R11 disabled region0");
    wr(OFF_CTL2, 32'h8000_0000); m_en[0] = 1'b1;

    // R9: inbound bank is separate
    prog(1'b1, 0, KIND_CFG1, 1'b1, 1'b1, 64'h0, 32'hFFFF_FFFF, 64'hDEAD_0000);
    prog(1'b1, 1, KIND_IO, 1'b1, 1'b0, 64'h3000_0000, 32'h3FFF_FFFF, 64'h0);
    view(1'b1, 0);
    readback(KIND_CFG1, 1'b1, 1'b1, 64'h0, 32'hFFFF_FFFF, 64'hDEAD_0000, "R9 inbound0");
    view(1'b0, 0);
    readback(KIND_MEM, 1'b1, 1'b0, 64'h1_1000_0000, 32'h1000_FFFF, 64'h4000_0000, "R9 outbound0");
    req_chk(64'h3000_1000, "R9 no inbound hit");
    sweep(0, "R9 region0 kept");

    // R12: unmapped offsets
    rd_chk(12'h920, 32'h0, "R12 read");
    rd_chk(12'h000, 32'h0, "R12 read");
    wr(12'h920, 32'hFFFF_FFFF); wr(12'h000, 32'hFFFF_FFFF); wr(12'h8FC, 32'hFFFF_FFFF);
    rd_chk(12'h920, 32'h0, "R12 after write");
    readback(KIND_MEM, 1'b1, 1'b0, 64'h1_1000_0000, 32'h1000_FFFF, 64'h4000_0000, "R12 region0 kept");
    req_chk(64'h1_1000_0004, "R12 translation kept");

    // R10: handshake pass-through
    @(negedge clk); req_valid = 1'b1; rsp_ready = 1'b0; #1;
    chk(req_ready == 1'b0, "R10 stall", {63'b0, req_ready}, 64'd0);
    chk(rsp_valid == 1'b1, "R10 valid", {63'b0, rsp_valid}, 64'd1);
    @(negedge clk); req_valid = 1'b0; rsp_ready = 1'b1; #1;
    chk(rsp_valid == 1'b0, "R10 idle", {63'b0, rsp_valid}, 64'd0);
    chk(req_ready == 1'b1, "R10 ready", {63'b0, req_ready}, 64'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule